// File: doc/BRIEF.md
# Program Counter Sequencing Unit

This block keeps the 11-bit fetch address of a small 8-bit controller and picks the next one once per instruction cycle. An instruction cycle spans four system clocks. An external phase strobe marks its boundary, and the address register moves only on that strobe. Fetch and execute overlap, so `pc_o` always names the word being fetched, one step ahead of the instruction being executed. The decoder raises its requests during the cycle in which the instruction that makes them is executing.

The next address comes from one of several sources under a fixed priority. The sources are the three interrupt vectors, a return from the stack, an absolute jump or call, a short jump made by writing the low address byte, a taken skip, and plain increment. Any change of flow throws away the word already fetched. The block marks the following instruction cycle as a dummy with `flush_o`. Requests that arrive during that dummy cycle are ignored, and the address simply advances. Calls and interrupt entries hand the return address to the stack with a one-cycle push strobe.

Top module: `pc_seq_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0x000, `flush_o` is 0 and `push_stb_o` is 0.
- R2: `pc_o` and `flush_o` change only at a clock edge where `cyc_stb_i` is high. Requests held while the strobe is low have no effect.
- R3: At a strobe with no request and `flush_o` low, `pc_o` becomes `pc_o`+1, wrapping from 0x7FF to 0x000, and `flush_o` stays 0.
- R4: Interrupt entry has priority over every decoder request. The time base goes to 0x004, timer 0 to 0x008 and timer 1 to 0x00C. When several are raised together, the time base wins, then timer 0.
- R5: A return loads `tos_i` into `pc_o`. It takes precedence over jump, call, low-byte write and skip, and it raises no push.
- R6: A jump or a call loads `imm_i` into `pc_o`, ahead of a low-byte write and a skip. Only a call pushes.
- R7: A low-byte write sets `pc_o[7:0]` to `low_data_i` and keeps `pc_o[10:8]`. It takes precedence over a skip.
- R8: A taken skip discards the fetched word and sets `pc_o` to `pc_o`+1, which is two past the skipping instruction, with wrap.
- R9: Every change of flow raises `flush_o` for exactly one instruction cycle. At the strobe that ends that cycle, all requests, including interrupts, are ignored and `pc_o` increments.
- R10: `pc_low_o` always equals `pc_o[7:0]`, which is the value read back from the low-byte register.
- R11: `push_stb_o` is high only at a strobe that takes a call or an interrupt entry. At that moment `push_addr_o` equals the current `pc_o`, which is the return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb_i | input | 1 | Instruction-cycle boundary strobe |
| irq_tb_i | input | 1 | Time base overflow request |
| irq_t0_i | input | 1 | Timer 0 overflow request |
| irq_t1_i | input | 1 | Timer 1 overflow request |
| ret_i | input | 1 | Return from subroutine |
| jmp_i | input | 1 | Absolute jump |
| call_i | input | 1 | Subroutine call |
| low_wr_i | input | 1 | Write to the low address byte |
| skip_i | input | 1 | Conditional skip taken |
| imm_i | input | 11 | Address field of the instruction |
| low_data_i | input | 8 | Value written to the low byte |
| tos_i | input | 11 | Top-of-stack address |
| pc_o | output | 11 | Current fetch address |
| pc_low_o | output | 8 | Low-byte read value |
| push_addr_o | output | 11 | Return address to push |
| push_stb_o | output | 1 | Push strobe |
| flush_o | output | 1 | Execute slot holds a discarded dummy |

## Verification
The properties assume that `cyc_stb_i` is a one-clock pulse and that the decoder's requests are valid while the strobe is high. They also rely on all flow checks being made against the registered `pc_o`, with no look back past reset. The directed stimulus sets up requests while the strobe is low, raises the strobe for exactly one clock, and keeps three quiet clocks between strobes. This matches the four-clock instruction cycle. Interrupt lines are deliberately left high across dummy cycles so that the ignore rule is tested.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    typedef enum logic [3:0] {
        SRC_HOLD,
        SRC_INC,
        SRC_SKIP,
        SRC_LOW,
        SRC_JMP,
        SRC_CALL,
        SRC_RET,
        SRC_TB,
        SRC_T0,
        SRC_T1
    } pc_src_e;

    localparam int NUM_VEC = 3;

endpackage

// File: rtl/pc_req_arb.sv
module pc_req_arb
    import pc_seq_pkg::*;
(
    input  logic                 stb_i,
    input  logic                 dummy_i,
    input  logic [NUM_VEC-1:0]   irq_i,
    input  logic                 ret_i,
    input  logic                 jmp_i,
    input  logic                 call_i,
    input  logic                 low_wr_i,
    input  logic                 skip_i,
    output pc_src_e              src_o
);

    // Fixed priority: vectors (index 0 highest), return, call/jump, low write, skip
    always_comb begin
        src_o = SRC_HOLD;
        if (stb_i) begin
            if (dummy_i)          src_o = SRC_INC;
            else if (irq_i[0])    src_o = SRC_TB;
            else if (irq_i[1])    src_o = SRC_T0;
            else if (irq_i[2])    src_o = SRC_T1;
            else if (ret_i)       src_o = SRC_RET;
            else if (call_i)      src_o = SRC_CALL;
            else if (jmp_i)       src_o = SRC_JMP;
            else if (low_wr_i)    src_o = SRC_LOW;
            else if (skip_i)      src_o = SRC_SKIP;
            else                  src_o = SRC_INC;
        end
    end

endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
    import pc_seq_pkg::*;
#(
    parameter int AW = 11,
    parameter int LW = 8,
    parameter int VEC_STEP = 4
)(
    input  pc_src_e          src_i,
    input  logic [AW-1:0]    pc_i,
    input  logic [AW-1:0]    imm_i,
    input  logic [LW-1:0]    low_i,
    input  logic [AW-1:0]    tos_i,
    output logic [AW-1:0]    next_o,
    output logic             xfer_o,
    output logic             push_o
);

    logic [AW-1:0] vec_addr [NUM_VEC];

    // Vector k sits at (k+1)*VEC_STEP
    for (genvar k = 0; k < NUM_VEC; k++) begin : g_vec
        assign vec_addr[k] = AW'((k + 1) * VEC_STEP);
    end

    always_comb begin
        next_o = pc_i;
        xfer_o = 1'b0;
        push_o = 1'b0;
        unique case (src_i)
            SRC_HOLD: next_o = pc_i;
            SRC_INC:  next_o = pc_i + 1'b1;
            SRC_SKIP: begin next_o = pc_i + 1'b1;          xfer_o = 1'b1; end
            SRC_LOW:  begin next_o = {pc_i[AW-1:LW], low_i}; xfer_o = 1'b1; end
            SRC_JMP:  begin next_o = imm_i;                xfer_o = 1'b1; end
            SRC_CALL: begin next_o = imm_i; xfer_o = 1'b1; push_o = 1'b1; end
            SRC_RET:  begin next_o = tos_i;                xfer_o = 1'b1; end
            SRC_TB:   begin next_o = vec_addr[0]; xfer_o = 1'b1; push_o = 1'b1; end
            SRC_T0:   begin next_o = vec_addr[1]; xfer_o = 1'b1; push_o = 1'b1; end
            SRC_T1:   begin next_o = vec_addr[2]; xfer_o = 1'b1; push_o = 1'b1; end
            default:  next_o = pc_i;
        endcase
    end

endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
    import pc_seq_pkg::*;
#(
    parameter int AW = 11,
    parameter int LW = 8,
    parameter int VEC_STEP = 4
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_stb_i,
    input  logic            irq_tb_i,
    input  logic            irq_t0_i,
    input  logic            irq_t1_i,
    input  logic            ret_i,
    input  logic            jmp_i,
    input  logic            call_i,
    input  logic            low_wr_i,
    input  logic            skip_i,
    input  logic [AW-1:0]   imm_i,
    input  logic [LW-1:0]   low_data_i,
    input  logic [AW-1:0]   tos_i,
    output logic [AW-1:0]   pc_o,
    output logic [LW-1:0]   pc_low_o,
    output logic [AW-1:0]   push_addr_o,
    output logic            push_stb_o,
    output logic            flush_o
);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          flush;
    } seq_state_t;

    seq_state_t st_d, st_q;
    pc_src_e    src;
    logic [AW-1:0] nxt_pc;
    logic       xfer, push;

    pc_req_arb u_arb (
        .stb_i    (cyc_stb_i),
        .dummy_i  (st_q.flush),
        .irq_i    ({irq_t1_i, irq_t0_i, irq_tb_i}),
        .ret_i    (ret_i),
        .jmp_i    (jmp_i),
        .call_i   (call_i),
        .low_wr_i (low_wr_i),
        .skip_i   (skip_i),
        .src_o    (src)
    );

    pc_next_sel #(.AW(AW), .LW(LW), .VEC_STEP(VEC_STEP)) u_sel (
        .src_i  (src),
        .pc_i   (st_q.pc),
        .imm_i  (imm_i),
        .low_i  (low_data_i),
        .tos_i  (tos_i),
        .next_o (nxt_pc),
        .xfer_o (xfer),
        .push_o (push)
    );

    always_comb begin
        st_d = st_q;
        if (cyc_stb_i) begin
            st_d.pc    = nxt_pc;
            st_d.flush = xfer;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o        = st_q.pc;
    assign pc_low_o    = st_q.pc[LW-1:0];
    assign flush_o     = st_q.flush;
    assign push_addr_o = st_q.pc;
    assign push_stb_o  = push;

    logic any_req;
    assign any_req = irq_tb_i | irq_t0_i | irq_t1_i | ret_i | jmp_i | call_i | low_wr_i | skip_i;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb_i |=> $stable(pc_o) && $stable(flush_o));

    p_seq_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_stb_i && !flush_o && !any_req |=> pc_o == AW'($past(pc_o) + 1'b1) && !flush_o);

    p_ret_tos_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_stb_i && !flush_o && ret_i && !(irq_tb_i | irq_t0_i | irq_t1_i) |=> pc_o == $past(tos_i));

    p_low_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_stb_i && !flush_o && low_wr_i && !(irq_tb_i | irq_t0_i | irq_t1_i | ret_i | jmp_i | call_i)
        |=> pc_o[AW-1:LW] == $past(pc_o[AW-1:LW]) && pc_o[LW-1:0] == $past(low_data_i));

    p_xfer_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_stb_i && !flush_o && any_req |=> flush_o);

    p_flush_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_stb_i && flush_o |=> !flush_o && pc_o == AW'($past(pc_o) + 1'b1));

    p_push_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push_stb_o |-> cyc_stb_i && !flush_o && (irq_tb_i | irq_t0_i | irq_t1_i | call_i));

endmodule

// File: tb/pc_seq_unit_test.sv
`timescale 1ns/1ps
module pc_seq_unit_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_stb = 1'b0;
    logic irq_tb = 0, irq_t0 = 0, irq_t1 = 0;
    logic ret = 0, jmp = 0, call = 0, low_wr = 0, skip = 0;
    logic [10:0] imm = '0, tos = '0;
    logic [7:0]  low_data = '0;
    logic [10:0] pc, push_addr;
    logic [7:0]  pc_low;
    logic        push_stb, flush;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic pushed;
    logic [10:0] pushv;

    always #10 clk = ~clk;

    pc_seq_unit uut (
        .clk(clk), .rst_n(rst_n), .cyc_stb_i(cyc_stb),
        .irq_tb_i(irq_tb), .irq_t0_i(irq_t0), .irq_t1_i(irq_t1),
        .ret_i(ret), .jmp_i(jmp), .call_i(call), .low_wr_i(low_wr), .skip_i(skip),
        .imm_i(imm), .low_data_i(low_data), .tos_i(tos),
        .pc_o(pc), .pc_low_o(pc_low), .push_addr_o(push_addr),
        .push_stb_o(push_stb), .flush_o(flush)
    );

    task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clr_req();
        irq_tb = 0; irq_t0 = 0; irq_t1 = 0;
        ret = 0; jmp = 0; call = 0; low_wr = 0; skip = 0;
    endtask

    // One instruction cycle: strobe for one clock, then three quiet clocks
    task automatic strobe();
        @(negedge clk);
        cyc_stb = 1'b1;
        #2;
        pushed = push_stb;
        pushv  = push_addr;
        @(negedge clk);
        cyc_stb = 1'b0;
        clr_req();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 pc after reset", pc, 11'h000);
        chk("R1 flush after reset", {10'd0, flush}, 11'd0);
        chk("R1 push after reset", {10'd0, push_stb}, 11'd0);
        chk("R10 low read after reset", {3'd0, pc_low}, 11'd0);
    endtask

    task automatic t_seq();
        strobe(); chk("R3 inc 1", pc, 11'h001);
        strobe(); chk("R3 inc 2", pc, 11'h002);
        strobe(); chk("R3 inc 3", pc, 11'h003);
        chk("R3 no flush", {10'd0, flush}, 11'd0);
    endtask

    task automatic t_hold();
        jmp = 1; imm = 11'h155; skip = 1; irq_tb = 1;
        repeat (6) @(negedge clk);
        chk("R2 pc held without strobe", pc, 11'h003);
        chk("R2 flush held without strobe", {10'd0, flush}, 11'd0);
        clr_req();
    endtask

    task automatic t_jump_dummy();
        jmp = 1; imm = 11'h155; low_wr = 1; low_data = 8'hEE; skip = 1;
        strobe();
        chk("R6 jump target", pc, 11'h155);
        chk("R6 jump no push", {10'd0, pushed}, 11'd0);
        chk("R9 flush after jump", {10'd0, flush}, 11'd1);
        jmp = 1; imm = 11'h300; irq_tb = 1; call = 1;
        strobe();
        chk("R9 dummy ignores requests", pc, 11'h156);
        chk("R9 dummy no push", {10'd0, pushed}, 11'd0);
        chk("R9 flush one cycle", {10'd0, flush}, 11'd0);
    endtask

    task automatic t_call_wrap();
        call = 1; jmp = 1; imm = 11'h7FE; skip = 1;
        strobe();
        chk("R6 call target", pc, 11'h7FE);
        chk("R11 call push strobe", {10'd0, pushed}, 11'd1);
        chk("R11 call return addr", pushv, 11'h156);
        strobe(); chk("R9 dummy after call", pc, 11'h7FF);
        strobe(); chk("R3 wrap to zero", pc, 11'h000);
    endtask

    task automatic t_ret();
        ret = 1; tos = 11'h2A0; jmp = 1; call = 1; imm = 11'h111; low_wr = 1;
        strobe();
        chk("R5 return target", pc, 11'h2A0);
        chk("R5 return no push", {10'd0, pushed}, 11'd0);
        strobe(); chk("R9 dummy after return", pc, 11'h2A1);
    endtask

    task automatic t_low_skip();
        low_wr = 1; low_data = 8'h10; skip = 1;
        strobe();
        chk("R7 low write keeps page", pc, 11'h210);
        chk("R9 flush after low write", {10'd0, flush}, 11'd1);
        strobe();
        chk("R10 low read", {3'd0, pc_low}, 11'h011);
        skip = 1;
        strobe();
        chk("R8 skip target", pc, 11'h212);
        chk("R8 skip flush", {10'd0, flush}, 11'd1);
        chk("R11 skip no push", {10'd0, pushed}, 11'd0);
        strobe(); chk("R9 dummy after skip", pc, 11'h213);
        jmp = 1; imm = 11'h7FE;
        strobe(); strobe();
        chk("R8 setup at top", pc, 11'h7FF);
        skip = 1;
        strobe(); chk("R8 skip wraps", pc, 11'h000);
        strobe(); chk("R9 dummy after wrap skip", pc, 11'h001);
    endtask

    task automatic t_irq();
        irq_tb = 1; irq_t0 = 1; irq_t1 = 1; ret = 1; tos = 11'h3C3; call = 1;
        strobe();
        chk("R4 time base vector", pc, 11'h004);
        chk("R11 irq push strobe", {10'd0, pushed}, 11'd1);
        chk("R11 irq return addr", pushv, 11'h001);
        irq_t0 = 1;
        strobe(); chk("R9 irq ignored in dummy", pc, 11'h005);
        irq_t0 = 1; irq_t1 = 1;
        strobe();
        chk("R4 timer0 vector", pc, 11'h008);
        chk("R11 timer0 return addr", pushv, 11'h005);
        strobe();
        irq_t1 = 1; jmp = 1; imm = 11'h444;
        strobe();
        chk("R4 timer1 vector", pc, 11'h00C);
        chk("R11 timer1 return addr", pushv, 11'h009);
    endtask

    task automatic t_reset_mid();
        @(negedge clk); rst_n = 0;
        #3;
        chk("R1 async reset pc", pc, 11'h000);
        chk("R1 async reset flush", {10'd0, flush}, 11'd0);
        @(negedge clk); rst_n = 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_seq();
        t_hold();
        t_jump_dummy();
        t_call_wrap();
        t_ret();
        t_low_skip();
        t_irq();
        t_reset_mid();
        finish_run();
    end

endmodule